// File: doc/BRIEF.md
# Programmable Rate and Square-Wave Counter

This block is one down-counting timer channel. A host loads a 16-bit period value and a mode bit through a one-cycle write strobe. While the gate input is high, the channel counts clock cycles and shapes a single wave output from the count. It has two modes. The rate mode drops the output low for one clock in every period. The square-wave mode splits each period into a high half and a low half.

The period reloads by itself at the end of every cycle. A host write does not disturb the period in progress: the new value and mode are used from the next reload on. Pulling the gate low freezes counting and holds the output high. Raising the gate again starts a fresh period from the stored value. Until the first write after reset the output stays high, whatever the gate does.

Top module: `wave_counter`

## Requirements
- R1: After reset, and until a count has been written, `wave_out` is high even with `gate` high.
- R2: Rate mode (`wr_mode` = 0) with count N (N >= 2): in steady state the output is high for N-1 clocks and then low for exactly 1 clock. The pattern repeats every N clocks with no host action.
- R3: Square mode (`wr_mode` = 1) with an even count N: the output is high for N/2 clocks and low for N/2 clocks, repeating.
- R4: Square mode with an odd count N (N >= 3): the output is high for (N+1)/2 clocks and low for (N-1)/2 clocks, repeating.
- R5: When `gate` is sampled low, `wave_out` is high from the next clock and stays high while `gate` stays low, including during a low phase that is in progress.
- R6: When `gate` is first sampled high after being low (the load clock), a full period starts from the stored count. In rate mode the first low pulse is driven at the N-th clock after the load clock.
- R7: A write while running does not alter the current period. The new count and mode take effect at the next reload.
- R8: A written count of 0 means 65536: in rate mode the first low pulse comes at the 65536-th clock after the load clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle strobe that stores `wr_count` and `wr_mode` |
| wr_count | input | 16 | Period value; 0 stands for 65536 |
| wr_mode | input | 1 | 0 = rate generator, 1 = square wave |
| gate | input | 1 | High enables counting; low holds the output high |
| wave_out | output | 1 | Registered wave output |

## Verification
The bench measures output run lengths for even and odd square-wave counts. A design that split the odd case the wrong way round would show a low phase one clock too long, and one that halved by truncation alone would shorten the period by a clock. It drops the gate partway through a square-wave low phase, which catches a design that freezes the output level instead of forcing it high. It writes a new count right after a rate pulse and checks that the following interval still uses the old count, which exposes a design that loads on write. It also checks the exact distance from the gate rise to the first pulse, and a zero count, where a design without the 65536 rule would pulse at once or never.

// File: rtl/wave_counter_pkg.sv
package wave_counter_pkg;
  typedef enum logic {
    MODE_RATE   = 1'b0,
    MODE_SQUARE = 1'b1
  } wave_mode_e;
endpackage

// File: rtl/wave_counter_hold.sv
// Holds the host-written period and mode; derives the load values.
module wave_counter_hold
  import wave_counter_pkg::*;
#(
  parameter int CW = 16,
  localparam int NW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_count,
  input  logic          wr_mode,
  output logic          armed,
  output wave_mode_e    ld_mode,
  output logic [NW-1:0] ld_full,
  output logic [NW-1:0] ld_hi,
  output logic [NW-1:0] ld_lo
);
  logic [CW-1:0] pend_n;
  logic [NW:0]   plus_one;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_n  <= '0;
      ld_mode <= MODE_RATE;
      armed   <= 1'b0;
    end else if (wr_en) begin
      pend_n  <= wr_count;
      ld_mode <= wave_mode_e'(wr_mode);
      armed   <= 1'b1;
    end
  end

  // A zero count stands for 2**CW.
  assign ld_full  = (pend_n == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, pend_n};
  assign plus_one = {1'b0, ld_full} + {{NW{1'b0}}, 1'b1};
  assign ld_hi    = plus_one[NW:1];
  assign ld_lo    = {1'b0, ld_full[NW-1:1]};
endmodule

// File: rtl/wave_counter_engine.sv
// Down-counter with gate control, period reload and output shaping.
module wave_counter_engine
  import wave_counter_pkg::*;
#(
  parameter int CW = 16,
  localparam int NW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate,
  input  logic          armed,
  input  wave_mode_e    ld_mode,
  input  logic [NW-1:0] ld_full,
  input  logic [NW-1:0] ld_hi,
  input  logic [NW-1:0] ld_lo,
  output logic          wave_out,
  output logic          run_o,
  output logic          phase_o,
  output logic [NW-1:0] cnt_o,
  output wave_mode_e    mode_o,
  output logic          gate_q_o
);
  localparam logic [NW-1:0] ONE = NW'(1);

  logic          run, ph, gate_q;
  logic [NW-1:0] cnt, lo_half, ld_cnt;
  wave_mode_e    mode;
  logic          start, step, at_end, split;

  always_comb begin
    ld_cnt = (ld_mode == MODE_SQUARE) ? ld_hi : ld_full;
    start  = gate && armed && (!run || !gate_q);
    step   = gate && run && !start;
    at_end = (cnt == ONE);
    split  = (mode == MODE_SQUARE) && ph && (lo_half != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      ph       <= 1'b1;
      gate_q   <= 1'b0;
      cnt      <= '0;
      lo_half  <= '0;
      mode     <= MODE_RATE;
      wave_out <= 1'b1;
    end else begin
      gate_q <= gate;
      if (!gate || start)
        wave_out <= 1'b1;
      else if (run)
        wave_out <= (mode == MODE_RATE) ? !at_end : ph;

      if (start || (step && at_end && !split)) begin
        run     <= 1'b1;
        ph      <= 1'b1;
        cnt     <= ld_cnt;
        mode    <= ld_mode;
        lo_half <= ld_lo;
      end else if (step && at_end) begin
        ph  <= 1'b0;
        cnt <= lo_half;
      end else if (step) begin
        cnt <= cnt - ONE;
      end
    end
  end

  assign run_o    = run;
  assign phase_o  = ph;
  assign cnt_o    = cnt;
  assign mode_o   = mode;
  assign gate_q_o = gate_q;
endmodule

// File: rtl/wave_counter.sv
module wave_counter
  import wave_counter_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_count,
  input  logic          wr_mode,
  input  logic          gate,
  output logic          wave_out
);
  localparam int NW = CW + 1;

  logic          armed, eng_run, eng_ph, eng_gate_q;
  wave_mode_e    ld_mode, eng_mode;
  logic [NW-1:0] ld_full, ld_hi, ld_lo, eng_cnt;

  wave_counter_hold #(.CW(CW)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_count(wr_count),
    .wr_mode(wr_mode), .armed(armed), .ld_mode(ld_mode),
    .ld_full(ld_full), .ld_hi(ld_hi), .ld_lo(ld_lo)
  );

  wave_counter_engine #(.CW(CW)) u_engine (
    .clk(clk), .rst(rst), .gate(gate), .armed(armed),
    .ld_mode(ld_mode), .ld_full(ld_full), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .wave_out(wave_out), .run_o(eng_run), .phase_o(eng_ph),
    .cnt_o(eng_cnt), .mode_o(eng_mode), .gate_q_o(eng_gate_q)
  );
endmodule

// File: rtl/wave_counter_chk.sv
module wave_counter_chk
  import wave_counter_pkg::*;
#(
  parameter int CW = 16,
  localparam int NW = CW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          gate,
  input logic          wr_en,
  input logic          wave_out,
  input logic          armed,
  input logic          run,
  input logic          gate_q,
  input logic [NW-1:0] cnt,
  input wave_mode_e    mode
);
  localparam logic [NW-1:0] ONE = NW'(1);
  localparam logic [NW-1:0] TOP = {1'b1, {CW{1'b0}}};

  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !armed |-> wave_out);

  a_r5_gate_low_high: assert property (@(posedge clk) disable iff (rst)
    !gate |=> wave_out);

  a_r8_cnt_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0 && cnt <= TOP));

  a_r2_rate_single_low: assert property (@(posedge clk) disable iff (rst)
    (run && gate && gate_q && mode == MODE_RATE && cnt != ONE) |=> wave_out);

  a_r7_write_no_disturb: assert property (@(posedge clk) disable iff (rst)
    (wr_en && run && gate && gate_q && cnt != ONE) |=> (cnt == $past(cnt) - ONE));
endmodule

bind wave_counter wave_counter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .gate(gate), .wr_en(wr_en), .wave_out(wave_out),
  .armed(armed), .run(eng_run), .gate_q(eng_gate_q), .cnt(eng_cnt),
  .mode(eng_mode)
);

// File: tb/wave_counter_bench.sv
`timescale 1ns/1ps
module wave_counter_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst, wr_en, wr_mode, gate;
  logic [CW-1:0] wr_count;
  logic          wave_out;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { logic lvl; int len; } run_t;
  run_t  exp_q[$];
  logic  mon_on = 1'b0;
  logic  mon_lvl = 1'b1;
  int    mon_len = 0;
  int    mon_skip = 0;
  string mon_req = "";

  always #4 clk = ~clk;

  wave_counter #(.CW(CW)) u_wave_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_count(wr_count),
    .wr_mode(wr_mode), .gate(gate), .wave_out(wave_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: measures run lengths and compares with the scoreboard queue.
  always @(negedge clk) begin
    run_t e;
    if (mon_on) begin
      if (wave_out === mon_lvl) mon_len++;
      else begin
        if (mon_skip > 0) mon_skip--;
        else if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          chk({mon_req, e.lvl ? " high run" : " low run"}, mon_len, e.len);
        end
        mon_lvl = wave_out;
        mon_len = 1;
      end
    end
  end

  task automatic write_count(input int n, input logic md);
    wr_en = 1'b1; wr_count = CW'(n); wr_mode = md;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: loads a pattern and pushes the expected steady-state runs.
  task automatic run_pattern(input logic md, input int n, input int periods,
                             input string req);
    int hi_len, lo_len;
    if (md) begin hi_len = (n + 1) / 2; lo_len = n / 2; end
    else begin hi_len = n - 1; lo_len = 1; end
    gate = 1'b0;
    write_count(n, md);
    repeat (2) @(negedge clk);
    mon_req = req; mon_skip = 1; mon_len = 0; mon_lvl = 1'b1; mon_on = 1'b1;
    for (int p = 0; p < periods; p++) begin
      exp_q.push_back('{1'b0, lo_len});
      exp_q.push_back('{1'b1, hi_len});
    end
    gate = 1'b1;
    while (exp_q.size() > 0) @(negedge clk);
    mon_on = 1'b0;
    gate = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Samples at successive negedges until the output is low.
  task automatic gap_to_low(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (wave_out !== 1'b0 && k < 70000);
  endtask

  task automatic wait_low();
    while (wave_out !== 1'b0) @(negedge clk);
  endtask

  initial begin
    int k, lows;
    rst = 1'b1; wr_en = 1'b0; wr_mode = 1'b0; gate = 1'b0; wr_count = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", wave_out, 1);
    gate = 1'b1;
    lows = 0;
    repeat (10) begin @(negedge clk); if (wave_out !== 1'b1) lows++; end
    chk("R1 gate high before first write", lows, 0);
    gate = 1'b0;
    @(negedge clk);

    run_pattern(1'b0, 3, 3, "R2 rate N=3");
    run_pattern(1'b0, 5, 3, "R2 rate N=5");
    run_pattern(1'b1, 6, 3, "R3 square N=6");
    run_pattern(1'b1, 2, 3, "R3 square N=2");
    run_pattern(1'b1, 7, 3, "R4 square N=7");
    run_pattern(1'b1, 3, 3, "R4 square N=3");

    // R6: restart distance from the gate rise.
    write_count(5, 1'b0);
    repeat (2) @(negedge clk);
    gate = 1'b1;
    gap_to_low(k);
    chk("R6 first pulse after gate rise", k, 6);
    gap_to_low(k);
    chk("R2 reload interval after restart", k, 5);
    gate = 1'b0;
    repeat (3) @(negedge clk);
    gate = 1'b1;
    gap_to_low(k);
    chk("R6 second restart from stored count", k, 6);
    gate = 1'b0;
    repeat (2) @(negedge clk);

    // R5: gate drop during a square-wave low phase.
    write_count(8, 1'b1);
    gate = 1'b1;
    @(negedge clk);
    wait_low();
    gate = 1'b0;
    @(negedge clk);
    chk("R5 gate low forces high", wave_out, 1);
    lows = 0;
    repeat (10) begin @(negedge clk); if (wave_out !== 1'b1) lows++; end
    chk("R5 held high while gate low", lows, 0);
    write_count(4, 1'b0);
    repeat (3) @(negedge clk);
    chk("R5 write with gate low keeps output high", wave_out, 1);

    // R7: write while running takes effect at the next reload.
    gate = 1'b1;
    @(negedge clk);
    wait_low();
    wr_en = 1'b1; wr_count = CW'(6); wr_mode = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    k = 1;
    while (wave_out !== 1'b0 && k < 100) begin @(negedge clk); k++; end
    chk("R7 current period unchanged", k, 4);
    gap_to_low(k);
    chk("R7 new count after reload", k, 6);
    gate = 1'b0;
    repeat (2) @(negedge clk);

    // R8: zero count means 65536.
    write_count(0, 1'b0);
    repeat (2) @(negedge clk);
    gate = 1'b1;
    gap_to_low(k);
    chk("R8 zero count period", k, 65537);
    gate = 1'b0;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule